// File: doc/BRIEF.md
# Handshaked Ethernet Core Reset Sequencer

This block drives the three active-low reset lines of an Ethernet MAC/PCS core: a global line, a transmit line and a receive line. It does not rely on fixed delays. Each step waits for the core's reset acknowledges (active low: low means that domain is fully held in reset) and for the core's two readiness flags, transmit lanes stable and receive PCS ready. The transmit and receive directions can each be reset alone, without touching the other direction or the global domain.

On the user side the block accepts single-cycle request pulses for a full, transmit-only or receive-only reset. It reports `busy`, `ready` and a sticky `error`. At power-up all three lines are held low, and the full release sequence then runs by itself. Every wait step is bounded by a cycle limit given on `timeout_cycles`. When a wait runs past that limit, the block sets `error`, pulls all three lines low and returns to idle. All acknowledge and status inputs pass through a two-flop synchronizer before the control logic uses them.

Top module: `eth_rst_seq`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `core_rst_n`, `tx_rst_n` and `rx_rst_n` are 0, `busy` is 1, `ready` is 0 and `error` is 0. The full release sequence then starts without any request.
- R2: `core_rst_n` rises only in a cycle where `tx_rst_n` and `rx_rst_n` are already 1.
- R3: `ready` is 1 only when both `tx_stable` and `rx_ready` are 1. After a full release, `ready` becomes 1 once the core acknowledges and both flags are high.
- R4: A transmit-only reset drives `tx_rst_n` to 0 while `core_rst_n` and `rx_rst_n` stay 1. `tx_rst_n` returns to 1 only after `tx_ack_n` has been seen low.
- R5: A receive-only reset drives `rx_rst_n` to 0 while `core_rst_n` and `tx_rst_n` stay 1. `rx_rst_n` returns to 1 only after `rx_ack_n` has been seen low.
- R6: A full reset drives all three lines to 0. `core_rst_n` is released only after `core_ack_n` has been seen low.
- R7: If any wait step lasts longer than `timeout_cycles` cycles, `error` is set, all three lines go to 0 and `busy` goes to 0 (idle). It does not fire earlier than `timeout_cycles` cycles into the step.
- R8: `error` stays 1 until `rst`. Later sequences still run while it is set.
- R9: When a full request and a transmit or receive request are pending together, the full sequence runs first. Accepting a full request discards any pending transmit or receive request.
- R10: A request that arrives while a sequence is running is held and served after the current sequence ends.
- R11: `ready` is 1 only when the block is idle with all three lines at 1. It drops to 0 within two cycles of a request pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| timeout_cycles | input | TO_W | Cycle limit for any wait step |
| req_full | input | 1 | One-cycle full reset request |
| req_tx | input | 1 | One-cycle transmit-only reset request |
| req_rx | input | 1 | One-cycle receive-only reset request |
| core_ack_n | input | 1 | Global reset acknowledge, low = held in reset |
| tx_ack_n | input | 1 | Transmit reset acknowledge, low = held in reset |
| rx_ack_n | input | 1 | Receive reset acknowledge, low = held in reset |
| tx_stable | input | 1 | Transmit lanes stable |
| rx_ready | input | 1 | Receive PCS ready |
| core_rst_n | output | 1 | Global reset to the core, active low |
| tx_rst_n | output | 1 | Transmit reset to the core, active low |
| rx_rst_n | output | 1 | Receive reset to the core, active low |
| busy | output | 1 | A sequence is in progress |
| ready | output | 1 | Core is out of reset and both flags are high |
| error | output | 1 | Sticky: a wait step timed out |

## Verification
A wrong state inside the block shows at the reset lines within one cycle of the bad transition. Typical signs are a global release while a direction line is still low, a direction line that drops during the other direction's reset, or a line released before its acknowledge was ever low. A wedged wait step shows at the ports no later than `timeout_cycles` plus a few cycles, as `error` rising with all lines low. A lost or misordered request shows as a missing or out-of-order falling edge on `tx_rst_n`, `rx_rst_n` or `core_rst_n` once the current sequence finishes.

// File: rtl/eth_rst_seq_pkg.sv
package eth_rst_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_G_HOLD,   // all lines low, wait for core ack low and both flags low
    ST_G_SIDE,   // release direction lines, core still low
    ST_G_REL,    // core released, wait core ack high
    ST_G_SUB,    // wait direction acks high
    ST_G_RDY,    // wait both readiness flags
    ST_T_HOLD,   // tx line low, wait tx ack low and lanes unstable
    ST_T_REL,    // tx released, wait tx ack high and lanes stable
    ST_R_HOLD,
    ST_R_REL
  } seq_st_e;

  // bit positions inside the synchronized input bus
  localparam int unsigned IN_CORE_ACK = 0;
  localparam int unsigned IN_TX_ACK   = 1;
  localparam int unsigned IN_RX_ACK   = 2;
  localparam int unsigned IN_TX_STAB  = 3;
  localparam int unsigned IN_RX_RDY   = 4;
  localparam int unsigned IN_W        = 5;

endpackage

// File: rtl/eth_rst_sync.sv
module eth_rst_sync #(
  parameter int unsigned W      = 5,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] INIT  = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) pipe[s] <= INIT;
    end else begin
      pipe[0] <= d;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/eth_rst_req.sv
module eth_rst_req (
  input  logic clk,
  input  logic rst,
  input  logic req_full,
  input  logic req_tx,
  input  logic req_rx,
  input  logic take_full,
  input  logic take_tx,
  input  logic take_rx,
  output logic pend_full,
  output logic pend_tx,
  output logic pend_rx
);

  // a full take also drops the direction requests: the full sequence covers them
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_full <= 1'b0;
      pend_tx   <= 1'b0;
      pend_rx   <= 1'b0;
    end else begin
      pend_full <= (pend_full & ~take_full) | req_full;
      pend_tx   <= (pend_tx & ~take_tx & ~take_full) | req_tx;
      pend_rx   <= (pend_rx & ~take_rx & ~take_full) | req_rx;
    end
  end

endmodule

// File: rtl/eth_rst_timer.sv
module eth_rst_timer #(
  parameter int unsigned TO_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            restart,
  input  logic            run,
  input  logic [TO_W-1:0] limit,
  output logic            expired
);

  localparam logic [TO_W-1:0] CNT_MAX = '1;

  logic [TO_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart || !run) cnt <= '0;
    else if (cnt != CNT_MAX)    cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt >= limit);

endmodule

// File: rtl/eth_rst_fsm.sv
module eth_rst_fsm
  import eth_rst_seq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [IN_W-1:0] ins,
  input  logic            pend_full,
  input  logic            pend_tx,
  input  logic            pend_rx,
  input  logic            expired,
  output logic            take_full,
  output logic            take_tx,
  output logic            take_rx,
  output logic            tmr_restart,
  output logic            tmr_run,
  output logic            core_rst_n,
  output logic            tx_rst_n,
  output logic            rx_rst_n,
  output logic            busy,
  output logic            ready,
  output logic            error
);

  seq_st_e st, nxt;
  logic n_core, n_tx, n_rx, set_err;

  logic core_ack, tx_ack, rx_ack, stab, rdy;
  assign core_ack = ins[IN_CORE_ACK];
  assign tx_ack   = ins[IN_TX_ACK];
  assign rx_ack   = ins[IN_RX_ACK];
  assign stab     = ins[IN_TX_STAB];
  assign rdy      = ins[IN_RX_RDY];

  // every state but idle and the one-cycle side release waits on the core
  assign tmr_run     = (st != ST_IDLE) && (st != ST_G_SIDE);
  assign tmr_restart = (nxt != st);

  always_comb begin
    nxt       = st;
    n_core    = core_rst_n;
    n_tx      = tx_rst_n;
    n_rx      = rx_rst_n;
    take_full = 1'b0;
    take_tx   = 1'b0;
    take_rx   = 1'b0;
    set_err   = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (pend_full) begin
          nxt = ST_G_HOLD; n_core = 1'b0; n_tx = 1'b0; n_rx = 1'b0;
          take_full = 1'b1;
        end else if (pend_tx) begin
          nxt = ST_T_HOLD; n_tx = 1'b0; take_tx = 1'b1;
        end else if (pend_rx) begin
          nxt = ST_R_HOLD; n_rx = 1'b0; take_rx = 1'b1;
        end
      end
      ST_G_HOLD: if (!core_ack && !stab && !rdy) begin
        nxt = ST_G_SIDE; n_tx = 1'b1; n_rx = 1'b1;
      end
      ST_G_SIDE: begin
        nxt = ST_G_REL; n_core = 1'b1;
      end
      ST_G_REL:  if (core_ack)          nxt = ST_G_SUB;
      ST_G_SUB:  if (tx_ack && rx_ack)  nxt = ST_G_RDY;
      ST_G_RDY:  if (stab && rdy)       nxt = ST_IDLE;
      ST_T_HOLD: if (!tx_ack && !stab) begin
        nxt = ST_T_REL; n_tx = 1'b1;
      end
      ST_T_REL:  if (tx_ack && stab)    nxt = ST_IDLE;
      ST_R_HOLD: if (!rx_ack && !rdy) begin
        nxt = ST_R_REL; n_rx = 1'b1;
      end
      ST_R_REL:  if (rx_ack && rdy)     nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
    if (tmr_run && expired) begin
      nxt     = ST_IDLE;
      n_core  = 1'b0;
      n_tx    = 1'b0;
      n_rx    = 1'b0;
      set_err = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_G_HOLD;
      core_rst_n <= 1'b0;
      tx_rst_n   <= 1'b0;
      rx_rst_n   <= 1'b0;
      busy       <= 1'b1;
      ready      <= 1'b0;
      error      <= 1'b0;
    end else begin
      st         <= nxt;
      core_rst_n <= n_core;
      tx_rst_n   <= n_tx;
      rx_rst_n   <= n_rx;
      busy       <= (nxt != ST_IDLE);
      ready      <= (nxt == ST_IDLE) && n_core && n_tx && n_rx && stab && rdy;
      error      <= error | set_err;
    end
  end

endmodule

// File: rtl/eth_rst_seq.sv
module eth_rst_seq
  import eth_rst_seq_pkg::*;
#(
  parameter int unsigned TO_W        = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [TO_W-1:0] timeout_cycles,
  input  logic            req_full,
  input  logic            req_tx,
  input  logic            req_rx,
  input  logic            core_ack_n,
  input  logic            tx_ack_n,
  input  logic            rx_ack_n,
  input  logic            tx_stable,
  input  logic            rx_ready,
  output logic            core_rst_n,
  output logic            tx_rst_n,
  output logic            rx_rst_n,
  output logic            busy,
  output logic            ready,
  output logic            error
);

  // acks start as "not in reset", flags as "not ready"
  localparam logic [IN_W-1:0] SYNC_INIT = IN_W'(5'b00111);

  logic [IN_W-1:0] raw_in, sync_in;
  logic core_ack_s, tx_ack_s, rx_ack_s;
  logic pend_full, pend_tx, pend_rx;
  logic take_full, take_tx, take_rx;
  logic tmr_restart, tmr_run, expired;

  always_comb begin
    raw_in              = '0;
    raw_in[IN_CORE_ACK] = core_ack_n;
    raw_in[IN_TX_ACK]   = tx_ack_n;
    raw_in[IN_RX_ACK]   = rx_ack_n;
    raw_in[IN_TX_STAB]  = tx_stable;
    raw_in[IN_RX_RDY]   = rx_ready;
  end

  eth_rst_sync #(.W(IN_W), .STAGES(SYNC_STAGES), .INIT(SYNC_INIT)) u_sync (
    .clk(clk), .rst(rst), .d(raw_in), .q(sync_in)
  );

  assign core_ack_s = sync_in[IN_CORE_ACK];
  assign tx_ack_s   = sync_in[IN_TX_ACK];
  assign rx_ack_s   = sync_in[IN_RX_ACK];

  eth_rst_req u_req (
    .clk(clk), .rst(rst),
    .req_full(req_full), .req_tx(req_tx), .req_rx(req_rx),
    .take_full(take_full), .take_tx(take_tx), .take_rx(take_rx),
    .pend_full(pend_full), .pend_tx(pend_tx), .pend_rx(pend_rx)
  );

  eth_rst_timer #(.TO_W(TO_W)) u_tmr (
    .clk(clk), .rst(rst), .restart(tmr_restart), .run(tmr_run),
    .limit(timeout_cycles), .expired(expired)
  );

  eth_rst_fsm u_fsm (
    .clk(clk), .rst(rst), .ins(sync_in),
    .pend_full(pend_full), .pend_tx(pend_tx), .pend_rx(pend_rx),
    .expired(expired),
    .take_full(take_full), .take_tx(take_tx), .take_rx(take_rx),
    .tmr_restart(tmr_restart), .tmr_run(tmr_run),
    .core_rst_n(core_rst_n), .tx_rst_n(tx_rst_n), .rx_rst_n(rx_rst_n),
    .busy(busy), .ready(ready), .error(error)
  );

endmodule

// File: rtl/eth_rst_seq_chk.sv
module eth_rst_seq_chk (
  input logic clk,
  input logic rst,
  input logic core_rst_n,
  input logic tx_rst_n,
  input logic rx_rst_n,
  input logic busy,
  input logic ready,
  input logic error,
  input logic tx_ack_s,
  input logic rx_ack_s
);

  assert_core_after_sides_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(core_rst_n) |-> (tx_rst_n && rx_rst_n));

  assert_tx_release_after_ack_R4: assert property (@(posedge clk) disable iff (rst)
    ($rose(tx_rst_n) && core_rst_n) |-> !$past(tx_ack_s));

  assert_rx_release_after_ack_R5: assert property (@(posedge clk) disable iff (rst)
    ($rose(rx_rst_n) && core_rst_n) |-> !$past(rx_ack_s));

  assert_timeout_drops_all_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(error) |-> (!core_rst_n && !tx_rst_n && !rx_rst_n && !busy));

  assert_error_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    error |=> error);

  assert_ready_idle_R11: assert property (@(posedge clk) disable iff (rst)
    ready |-> (!busy && core_rst_n && tx_rst_n && rx_rst_n));

endmodule

bind eth_rst_seq eth_rst_seq_chk u_chk (
  .clk(clk), .rst(rst),
  .core_rst_n(core_rst_n), .tx_rst_n(tx_rst_n), .rx_rst_n(rx_rst_n),
  .busy(busy), .ready(ready), .error(error),
  .tx_ack_s(tx_ack_s), .rx_ack_s(rx_ack_s)
);

// File: tb/tb_eth_rst_seq.sv
module tb_eth_rst_seq;

  localparam int TO_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [TO_W-1:0] to_lim = 16'd200;
  logic req_full = 1'b0, req_tx = 1'b0, req_rx = 1'b0;
  logic core_ack_n, tx_ack_n, rx_ack_n, tx_stable, rx_ready;
  logic core_rst_n, tx_rst_n, rx_rst_n, busy, ready, error;
  logic hang_tx = 1'b0;

  int total = 0, bad = 0, cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  eth_rst_seq #(.TO_W(TO_W)) dut (
    .clk(clk), .rst(rst), .timeout_cycles(to_lim),
    .req_full(req_full), .req_tx(req_tx), .req_rx(req_rx),
    .core_ack_n(core_ack_n), .tx_ack_n(tx_ack_n), .rx_ack_n(rx_ack_n),
    .tx_stable(tx_stable), .rx_ready(rx_ready),
    .core_rst_n(core_rst_n), .tx_rst_n(tx_rst_n), .rx_rst_n(rx_rst_n),
    .busy(busy), .ready(ready), .error(error)
  );

  // behavioural core: each output follows its reset line after 3 cycles
  logic [2:0][4:0] sp = '0;
  logic [4:0] tgt;
  always_comb begin
    tgt[0] = core_rst_n;
    tgt[1] = (core_rst_n && tx_rst_n) || hang_tx;
    tgt[2] = core_rst_n && rx_rst_n;
    tgt[3] = core_rst_n && tx_rst_n;
    tgt[4] = core_rst_n && rx_rst_n;
  end
  always_ff @(posedge clk) begin
    sp[0] <= tgt;
    sp[1] <= sp[0];
    sp[2] <= sp[1];
  end
  assign core_ack_n = sp[2][0];
  assign tx_ack_n   = sp[2][1];
  assign rx_ack_n   = sp[2][2];
  assign tx_stable  = sp[2][3];
  assign rx_ready   = sp[2][4];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // port monitors
  logic p_core = 1'b0, p_tx = 1'b0, p_rx = 1'b0, p_err = 1'b0;
  bit core_seen = 0, tx_seen = 0, rx_seen = 0, in_tx = 0, in_rx = 0;
  int v_r2 = 0, v_r3 = 0, v_r4 = 0, v_r5 = 0, v_r6 = 0, v_r8 = 0;
  int tx_only = 0, rx_only = 0, full_cnt = 0;
  int first_fall = 0;  // 1 core, 2 tx-only, 3 rx-only

  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      p_core = 0; p_tx = 0; p_rx = 0; p_err = 0;
      core_seen = 0; tx_seen = 0; rx_seen = 0; in_tx = 0; in_rx = 0;
    end else begin
      if (!core_rst_n && !core_ack_n) core_seen = 1;
      if (!tx_rst_n && !tx_ack_n) tx_seen = 1;
      if (!rx_rst_n && !rx_ack_n) rx_seen = 1;
      if (!p_core && core_rst_n) begin
        if (!(tx_rst_n && rx_rst_n)) v_r2++;
        if (!core_seen) v_r6++;
      end
      if (p_core && !core_rst_n) begin
        core_seen = 0; tx_seen = 0; rx_seen = 0;
        if (!error) begin full_cnt++; if (first_fall == 0) first_fall = 1; end
      end
      if (p_tx && !tx_rst_n && core_rst_n) begin
        tx_only++; in_tx = 1; tx_seen = 0;
        if (first_fall == 0) first_fall = 2;
      end
      if (p_rx && !rx_rst_n && core_rst_n) begin
        rx_only++; in_rx = 1; rx_seen = 0;
        if (first_fall == 0) first_fall = 3;
      end
      if (!p_tx && tx_rst_n && core_rst_n && p_core && !tx_seen) v_r4++;
      if (!p_rx && rx_rst_n && core_rst_n && p_core && !rx_seen) v_r5++;
      if (error) begin in_tx = 0; in_rx = 0; end
      if (in_tx && (!core_rst_n || !rx_rst_n)) v_r4++;
      if (in_rx && (!core_rst_n || !tx_rst_n)) v_r5++;
      if (ready) begin in_tx = 0; in_rx = 0; end
      if (ready && !(tx_stable && rx_ready)) v_r3++;
      if (p_err && !error) v_r8++;
      p_core = core_rst_n; p_tx = tx_rst_n; p_rx = rx_rst_n; p_err = error;
    end
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input bit f, input bit t, input bit r);
    @(negedge clk);
    req_full = f; req_tx = t; req_rx = r;
    @(negedge clk);
    req_full = 0; req_tx = 0; req_rx = 0;
  endtask

  task automatic wait_ready(input int lim, output bit got);
    got = 0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (ready) begin got = 1; break; end
    end
  endtask

  initial begin : watchdog
    while (!done && cyc < 100000) @(negedge clk);
    if (!done) begin
      check(0, "watchdog", cyc, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    bit got;
    int b_tx, b_rx, b_full;
    // R1 power-up
    cycles(3);
    check(!core_rst_n && !tx_rst_n && !rx_rst_n, "R1 lines low in rst", {core_rst_n, tx_rst_n, rx_rst_n}, 0);
    check(busy && !ready && !error, "R1 status in rst", {busy, ready, error}, 4);
    rst = 0;
    @(negedge clk);
    check(!core_rst_n && !tx_rst_n && !rx_rst_n && busy, "R1 after rst", {core_rst_n, tx_rst_n, rx_rst_n, busy}, 1);
    wait_ready(200, got);
    check(got, "R1 auto release", got, 1);
    check(tx_stable && rx_ready, "R3 flags at ready", {tx_stable, rx_ready}, 3);

    // R4 tx-only, R11 ready drop
    b_tx = tx_only;
    pulse(0, 1, 0);
    @(negedge clk);
    check(!ready && busy, "R11 ready drop", {ready, busy}, 1);
    wait_ready(200, got);
    check(got && tx_only == b_tx + 1, "R4 tx-only sequence", tx_only, b_tx + 1);

    // R5 rx-only
    b_rx = rx_only;
    pulse(0, 0, 1);
    wait_ready(200, got);
    check(got && rx_only == b_rx + 1, "R5 rx-only sequence", rx_only, b_rx + 1);

    // R9 priority: full with tx together
    first_fall = 0; b_tx = tx_only; b_full = full_cnt;
    pulse(1, 1, 1);
    wait_ready(300, got);
    check(first_fall == 1, "R9 full served first", first_fall, 1);
    check(got && tx_only == b_tx && full_cnt == b_full + 1, "R9 direction requests dropped",
          tx_only - b_tx, 0);

    // R10 latched during sequence
    b_tx = tx_only; b_rx = rx_only; first_fall = 0;
    pulse(0, 0, 1);
    cycles(2);
    check(busy, "R10 busy mid sequence", busy, 1);
    pulse(0, 1, 0);
    wait_ready(300, got);
    if (!tx_rst_n || tx_only == b_tx) wait_ready(300, got);
    cycles(20);
    check(rx_only == b_rx + 1 && tx_only == b_tx + 1 && first_fall == 3, "R10 both served in order",
          tx_only - b_tx + rx_only - b_rx, 2);
    check(ready, "R10 ready after both", ready, 1);

    // R7 timeout
    to_lim = 16'd20; hang_tx = 1;
    pulse(0, 1, 0);
    cycles(10);
    check(!error, "R7 no early timeout", error, 0);
    got = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (error) begin got = 1; break; end end
    check(got, "R7 timeout raised", error, 1);
    check(!core_rst_n && !tx_rst_n && !rx_rst_n && !busy && !ready, "R7 all low idle",
          {core_rst_n, tx_rst_n, rx_rst_n, busy, ready}, 0);

    // R8 sticky, recovery still works
    hang_tx = 0; to_lim = 16'd200;
    cycles(10);
    check(error && !core_rst_n, "R8 sticky idle held", {error, core_rst_n}, 2);
    pulse(1, 0, 0);
    wait_ready(300, got);
    check(got && error, "R8 sequence runs with error", {got, error}, 3);
    rst = 1;
    cycles(2);
    rst = 0;
    @(negedge clk);
    check(!error && busy && !core_rst_n, "R8 error cleared by rst", {error, busy, core_rst_n}, 2);
    wait_ready(200, got);
    check(got, "R6 release after re-rst", got, 1);

    // monitor totals
    check(v_r2 == 0, "R2 global after sides", v_r2, 0);
    check(v_r3 == 0, "R3 ready with flags", v_r3, 0);
    check(v_r4 == 0, "R4 tx isolation and ack", v_r4, 0);
    check(v_r5 == 0, "R5 rx isolation and ack", v_r5, 0);
    check(v_r6 == 0, "R6 core ack before release", v_r6, 0);
    check(v_r8 == 0, "R8 error never fell", v_r8, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule